// File: doc/BRIEF.md
# Nibble-Stack Branch and Call Sequencer

This block controls the program counter of a small 4-bit processor core. It keeps the program counter as three fields: a one-bit bank, a 4-bit page and an 8-bit step address. It also keeps two pending latches, one for the bank and one for the page. A preset operation loads these latches, and every later jump or call builds its target from them. A call saves the return address as three 4-bit words on a stack in nibble-wide data memory. A return reads the three words back. There are two extra forms of return: one advances past the next instruction, and one also stores an 8-bit literal at the index address.

The surrounding core gives the block a decoded operation code together with an 8-bit immediate, the carry and zero flags, the A and B nibbles and the index address X. The block then runs the operation over a fixed number of clocks. It uses a memory read port and a memory write port, at most one access of each per clock. Busy stays high for the whole operation. The core may present a new operation only while busy is low. Instruction fetch, arithmetic and interrupts are outside this block.

Top module: `nibstack_pc_seq`

## Requirements
- R1: After reset the bank is 0, the page is 1, the step address is 0x00, the stack pointer is 0x00, both pending latches are 0, busy is low, and there are no memory writes or index writes.
- R2: Preset (op code 0) copies immediate bit 4 into the pending bank and immediate bits 3:0 into the pending page. It leaves the program counter unchanged.
- R3: Jump (op code 1) loads the bank from the pending bank, the page from the pending page and the step address from the immediate.
- R4: The conditional jumps act like op code 1 only when their condition holds: op code 2 when C=1, op code 3 when C=0, op code 4 when Z=1, op code 5 when Z=0. When the condition fails, the program counter is left unchanged.
- R5: Register jump (op code 6) loads the bank and page from the pending latches. It loads step bits 7:4 from B and step bits 3:0 from A.
- R6: Call (op code 7) makes three writes: the page to SP-1, step bits 7:4 to SP-2, and (step bits 3:0 + 1) mod 16 to SP-3. It then lowers SP by 3, loads the page from the pending page and the step address from the immediate, and leaves the bank unchanged.
- R7: Zero-page call (op code 8) makes the same three writes and the same SP change as op code 7, but it sets the page to 0.
- R8: Return (op code 9) rebuilds the program counter from three words: step bits 3:0 from M(SP), step bits 7:4 from M(SP+1) and the page from M(SP+2). It then raises SP by 3 and leaves the bank unchanged.
- R9: Skip return (op code 10) restores the program counter like op code 9 and then adds 1 to the 12-bit {page, step} value. A carry out of the step address goes into the page.
- R10: Data return (op code 11) restores the program counter like op code 9. It also writes immediate bits 3:0 to M(X) and immediate bits 7:4 to M(X+1), and it outputs X+2 on the index write port with a one-cycle strobe.
- R11: Busy is high for exactly 5 cycles for op codes 0 to 6, 7 cycles for op codes 7 to 9, and 12 cycles for op codes 10 and 11. The new program counter and SP appear in the cycle in which busy falls.
- R12: An operation presented while busy is high is ignored. Op codes 12 to 15 are ignored: busy stays low and the state does not change.
- R13: SP and all stack and index addresses wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op | input | 4 | Decoded operation code |
| imm | input | 8 | Immediate operand |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| reg_a | input | 4 | A register |
| reg_b | input | 4 | B register |
| idx_x | input | 8 | Index address X |
| mem_rdata | input | 4 | Data read from mem_raddr, same cycle |
| mem_raddr | output | 8 | Read address |
| mem_we | output | 1 | Write strobe |
| mem_waddr | output | 8 | Write address |
| mem_wdata | output | 4 | Write data |
| pc_bank | output | 1 | Program counter bank |
| pc_page | output | 4 | Program counter page |
| pc_step | output | 8 | Program counter step address |
| sp | output | 8 | Stack pointer |
| x_we | output | 1 | Index update strobe |
| x_wdata | output | 8 | New index value |
| busy | output | 1 | Operation in progress |

## Verification
Suppose a pending latch holds a wrong value. The ports show nothing until the next jump or call, and then the target lands on the wrong bank or page when busy falls. A fault in the step counter shows up at once: the memory write strobes come in the wrong cycles, and the busy pulse has the wrong length. A wrong captured stack word is not visible until the return commits, and then it shows as a wrong program counter. So the bench checks every operation at the cycle in which busy falls, and it also checks the memory image after each call.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [3:0] {
        OP_PSET = 4'd0,
        OP_JP   = 4'd1,
        OP_JPC  = 4'd2,
        OP_JPNC = 4'd3,
        OP_JPZ  = 4'd4,
        OP_JPNZ = 4'd5,
        OP_JPBA = 4'd6,
        OP_CALL = 4'd7,
        OP_CALZ = 4'd8,
        OP_RET  = 4'd9,
        OP_RETS = 4'd10,
        OP_RETD = 4'd11
    } nps_op_e;

    function automatic logic op_known(input logic [3:0] o);
        return o <= OP_RETD;
    endfunction

    function automatic logic op_is_call(input logic [3:0] o);
        return (o == OP_CALL) || (o == OP_CALZ);
    endfunction

    function automatic logic op_is_ret(input logic [3:0] o);
        return (o == OP_RET) || (o == OP_RETS) || (o == OP_RETD);
    endfunction

endpackage

// File: rtl/nps_timer.sv
module nps_timer #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STEP_W-1:0] len,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              last
);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] len;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.step == t_q.len - STEP_W'(1)) begin
                t_d.busy = 1'b0;
                t_d.step = '0;
            end else begin
                t_d.step = t_q.step + STEP_W'(1);
            end
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.step = '0;
            t_d.len  = len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;
    assign step = t_q.step;
    assign last = t_q.busy && (t_q.step == t_q.len - STEP_W'(1));

endmodule

// File: rtl/nps_memport.sv
module nps_memport
    import nps_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STEP_W = 4
) (
    input  logic [3:0]        op,
    input  logic              busy,
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] x,
    input  logic [3:0]        pcp,
    input  logic [7:0]        pcs,
    input  logic [7:0]        imm,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [3:0]        wdata
);

    // Pops read SP, SP+1, SP+2 in steps 0..2; the address simply tracks the step.
    assign raddr = sp + ADDR_W'(step);

    always_comb begin
        we    = 1'b0;
        waddr = sp;
        wdata = '0;
        if (busy && op_is_call(op)) begin
            case (step)
                STEP_W'(0): begin we = 1'b1; waddr = sp - ADDR_W'(1); wdata = pcp; end
                STEP_W'(1): begin we = 1'b1; waddr = sp - ADDR_W'(2); wdata = pcs[7:4]; end
                STEP_W'(2): begin we = 1'b1; waddr = sp - ADDR_W'(3); wdata = pcs[3:0] + 4'd1; end
                default: ;
            endcase
        end else if (busy && (op == OP_RETD)) begin
            case (step)
                STEP_W'(3): begin we = 1'b1; waddr = x;                wdata = imm[3:0]; end
                STEP_W'(4): begin we = 1'b1; waddr = x + ADDR_W'(1);   wdata = imm[7:4]; end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nps_target.sv
module nps_target
    import nps_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [3:0]        op,
    input  logic              taken,
    input  logic              nbank,
    input  logic [3:0]        npage,
    input  logic [7:0]        imm,
    input  logic [3:0]        reg_a,
    input  logic [3:0]        reg_b,
    input  logic [3:0]        pop_l,
    input  logic [3:0]        pop_h,
    input  logic [3:0]        pop_p,
    input  logic              cur_pcb,
    input  logic [3:0]        cur_pcp,
    input  logic [7:0]        cur_pcs,
    input  logic [ADDR_W-1:0] cur_sp,
    input  logic [ADDR_W-1:0] cur_x,
    output logic              n_pcb,
    output logic [3:0]        n_pcp,
    output logic [7:0]        n_pcs,
    output logic [ADDR_W-1:0] n_sp,
    output logic [ADDR_W-1:0] n_x,
    output logic              n_nbank,
    output logic [3:0]        n_npage
);

    logic [11:0] popped;
    logic [11:0] popped_inc;

    assign popped     = {pop_p, pop_h, pop_l};
    assign popped_inc = popped + 12'd1;

    always_comb begin
        n_pcb   = cur_pcb;
        n_pcp   = cur_pcp;
        n_pcs   = cur_pcs;
        n_sp    = cur_sp;
        n_x     = cur_x;
        n_nbank = nbank;
        n_npage = npage;
        case (op)
            OP_PSET: begin
                n_nbank = imm[4];
                n_npage = imm[3:0];
            end
            OP_JP, OP_JPC, OP_JPNC, OP_JPZ, OP_JPNZ: begin
                if (taken) begin
                    n_pcb = nbank;
                    n_pcp = npage;
                    n_pcs = imm;
                end
            end
            OP_JPBA: begin
                n_pcb = nbank;
                n_pcp = npage;
                n_pcs = {reg_b, reg_a};
            end
            OP_CALL, OP_CALZ: begin
                n_sp  = cur_sp - ADDR_W'(3);
                n_pcp = (op == OP_CALZ) ? 4'd0 : npage;
                n_pcs = imm;
            end
            OP_RET, OP_RETD: begin
                n_sp           = cur_sp + ADDR_W'(3);
                {n_pcp, n_pcs} = popped;
                if (op == OP_RETD) n_x = cur_x + ADDR_W'(2);
            end
            OP_RETS: begin
                n_sp           = cur_sp + ADDR_W'(3);
                {n_pcp, n_pcs} = popped_inc;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nibstack_pc_seq.sv
module nibstack_pc_seq
    import nps_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         CYC_JUMP   = 5,
    parameter int         CYC_CALL   = 7,
    parameter int         CYC_LONG   = 12,
    parameter logic [3:0] RESET_PAGE = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op,
    input  logic [7:0]        imm,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic [3:0]        reg_a,
    input  logic [3:0]        reg_b,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [3:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [3:0]        mem_wdata,
    output logic              pc_bank,
    output logic [3:0]        pc_page,
    output logic [7:0]        pc_step,
    output logic [ADDR_W-1:0] sp,
    output logic              x_we,
    output logic [ADDR_W-1:0] x_wdata,
    output logic              busy
);

    localparam int STEP_W = $clog2(CYC_LONG + 1);

    typedef struct packed {
        logic              pcb;
        logic [3:0]        pcp;
        logic [7:0]        pcs;
        logic [ADDR_W-1:0] sp;
        logic              nbank;
        logic [3:0]        npage;
        logic [3:0]        op;
        logic [7:0]        imm;
        logic [3:0]        a;
        logic [3:0]        b;
        logic [ADDR_W-1:0] x;
        logic              taken;
        logic [3:0]        pop_l;
        logic [3:0]        pop_h;
        logic [3:0]        pop_p;
    } seq_t;

    seq_t s_d, s_q;

    logic              start;
    logic [STEP_W-1:0] len;
    logic [STEP_W-1:0] step;
    logic              last;
    logic              take_now;

    logic              t_pcb, t_nbank;
    logic [3:0]        t_pcp, t_npage;
    logic [7:0]        t_pcs;
    logic [ADDR_W-1:0] t_sp, t_x;

    assign start = op_valid && !busy && op_known(op);

    always_comb begin
        case (op)
            OP_CALL, OP_CALZ, OP_RET: len = STEP_W'(CYC_CALL);
            OP_RETS, OP_RETD:         len = STEP_W'(CYC_LONG);
            default:                  len = STEP_W'(CYC_JUMP);
        endcase
        case (op)
            OP_JPC:  take_now = flag_c;
            OP_JPNC: take_now = !flag_c;
            OP_JPZ:  take_now = flag_z;
            OP_JPNZ: take_now = !flag_z;
            default: take_now = 1'b1;
        endcase
    end

    nps_timer #(.STEP_W(STEP_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len   (len),
        .busy  (busy),
        .step  (step),
        .last  (last)
    );

    nps_memport #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_memport (
        .op    (s_q.op),
        .busy  (busy),
        .step  (step),
        .sp    (s_q.sp),
        .x     (s_q.x),
        .pcp   (s_q.pcp),
        .pcs   (s_q.pcs),
        .imm   (s_q.imm),
        .raddr (mem_raddr),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    nps_target #(.ADDR_W(ADDR_W)) u_target (
        .op      (s_q.op),
        .taken   (s_q.taken),
        .nbank   (s_q.nbank),
        .npage   (s_q.npage),
        .imm     (s_q.imm),
        .reg_a   (s_q.a),
        .reg_b   (s_q.b),
        .pop_l   (s_q.pop_l),
        .pop_h   (s_q.pop_h),
        .pop_p   (s_q.pop_p),
        .cur_pcb (s_q.pcb),
        .cur_pcp (s_q.pcp),
        .cur_pcs (s_q.pcs),
        .cur_sp  (s_q.sp),
        .cur_x   (s_q.x),
        .n_pcb   (t_pcb),
        .n_pcp   (t_pcp),
        .n_pcs   (t_pcs),
        .n_sp    (t_sp),
        .n_x     (t_x),
        .n_nbank (t_nbank),
        .n_npage (t_npage)
    );

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.op    = op;
            s_d.imm   = imm;
            s_d.a     = reg_a;
            s_d.b     = reg_b;
            s_d.x     = idx_x;
            s_d.taken = take_now;
        end
        if (busy && op_is_ret(s_q.op)) begin
            case (step)
                STEP_W'(0): s_d.pop_l = mem_rdata;
                STEP_W'(1): s_d.pop_h = mem_rdata;
                STEP_W'(2): s_d.pop_p = mem_rdata;
                default: ;
            endcase
        end
        if (last) begin
            s_d.pcb   = t_pcb;
            s_d.pcp   = t_pcp;
            s_d.pcs   = t_pcs;
            s_d.sp    = t_sp;
            s_d.nbank = t_nbank;
            s_d.npage = t_npage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.pcp <= RESET_PAGE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc_bank = s_q.pcb;
    assign pc_page = s_q.pcp;
    assign pc_step = s_q.pcs;
    assign sp      = s_q.sp;
    assign x_we    = last && (s_q.op == OP_RETD);
    assign x_wdata = t_x;

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
    parameter int ADDR_W   = 8,
    parameter int CYC_JUMP = 5,
    parameter int CYC_CALL = 7,
    parameter int CYC_LONG = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_we,
    input logic              x_we,
    input logic [ADDR_W-1:0] sp,
    input logic              pc_bank,
    input logic [3:0]        pc_page,
    input logic [7:0]        pc_step
);

    logic [7:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt_q <= '0;
        else if (busy) busy_cnt_q <= busy_cnt_q + 8'd1;
        else           busy_cnt_q <= '0;
    end

    // R11: each busy pulse has one of the three legal lengths
    a_r11_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt_q == 8'(CYC_JUMP) || busy_cnt_q == 8'(CYC_CALL)
                         || busy_cnt_q == 8'(CYC_LONG)));

    // R12: program counter holds while an operation runs, changing only at the end
    a_r12_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable({pc_bank, pc_page, pc_step})));

    // R12: stack pointer holds while an operation runs
    a_r12_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(sp)));

    // R13: at completion SP moved by 0, +3 or -3 modulo 256
    a_r13_sp_delta: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sp == $past(sp) || sp == ADDR_W'($past(sp) + ADDR_W'(3))
                         || sp == ADDR_W'($past(sp) - ADDR_W'(3))));

    // R6: memory writes happen only inside an operation
    a_r6_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R10: index strobe is a single cycle inside an operation
    a_r10_x_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        x_we |-> (busy && !mem_we) ##1 !x_we);

endmodule

bind nibstack_pc_seq nps_checker #(
    .ADDR_W(ADDR_W), .CYC_JUMP(CYC_JUMP), .CYC_CALL(CYC_CALL), .CYC_LONG(CYC_LONG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .x_we(x_we),
    .sp(sp), .pc_bank(pc_bank), .pc_page(pc_page), .pc_step(pc_step)
);

// File: tb/nibstack_pc_seq_test.sv
module nibstack_pc_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] imm = '0;
    logic       flag_c = 1'b0, flag_z = 1'b0;
    logic [3:0] reg_a = '0, reg_b = '0;
    logic [7:0] idx_x = '0;
    logic [3:0] mem_rdata;
    logic [7:0] mem_raddr, mem_waddr, sp, x_wdata;
    logic       mem_we, pc_bank, x_we, busy;
    logic [3:0] mem_wdata, pc_page;
    logic [7:0] pc_step;

    logic [3:0] mem [256];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [3:0] pre_data = '0;

    int checks = 0;
    int fails  = 0;
    int ncyc;
    logic       xw_seen;
    logic [7:0] xw_val;

    always #2 clk = ~clk;

    nibstack_pc_seq uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .imm(imm),
        .flag_c(flag_c), .flag_z(flag_z), .reg_a(reg_a), .reg_b(reg_b),
        .idx_x(idx_x), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .pc_bank(pc_bank), .pc_page(pc_page), .pc_step(pc_step), .sp(sp),
        .x_we(x_we), .x_wdata(x_wdata), .busy(busy)
    );

    assign mem_rdata = mem[mem_raddr];

    always @(posedge clk) begin
        if (pre_we)      mem[pre_addr]  <= pre_data;
        else if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_pc(input string req, input int bank, input int page, input int step);
        check(req, "pc", int'({pc_bank, pc_page, pc_step}), (bank << 12) | (page << 8) | step);
    endtask

    task automatic preload(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run_op(input logic [3:0] o, input logic [7:0] im, input logic c,
                          input logic z, input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        op_valid = 1'b1; op = o; imm = im; flag_c = c; flag_z = z; reg_a = a; reg_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        ncyc = 0;
        xw_seen = 1'b0;
        xw_val = '0;
        while (busy && ncyc < 50) begin
            if (x_we) begin xw_seen = 1'b1; xw_val = x_wdata; end
            ncyc++;
            @(negedge clk);
        end
    endtask

    // {op, imm, c, z, a, b, exp bank, exp page, exp step, exp cycles}
    localparam logic [38:0] VEC [12] = '{
        {4'd0, 8'h15, 1'b0, 1'b0, 4'h0, 4'h0, 1'b0, 4'h1, 8'h00, 4'd5},
        {4'd1, 8'h3C, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h3C, 4'd5},
        {4'd2, 8'h77, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h3C, 4'd5},
        {4'd2, 8'h77, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h77, 4'd5},
        {4'd3, 8'h11, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h77, 4'd5},
        {4'd3, 8'h11, 1'b0, 1'b1, 4'h0, 4'h0, 1'b1, 4'h5, 8'h11, 4'd5},
        {4'd4, 8'h22, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h11, 4'd5},
        {4'd4, 8'h22, 1'b0, 1'b1, 4'h0, 4'h0, 1'b1, 4'h5, 8'h22, 4'd5},
        {4'd5, 8'h33, 1'b0, 1'b1, 4'h0, 4'h0, 1'b1, 4'h5, 8'h22, 4'd5},
        {4'd5, 8'h33, 1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h33, 4'd5},
        {4'd0, 8'h0A, 1'b0, 1'b0, 4'h0, 4'h0, 1'b1, 4'h5, 8'h33, 4'd5},
        {4'd6, 8'h00, 1'b0, 1'b0, 4'h4, 4'h9, 1'b0, 4'hA, 8'h94, 4'd5}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pc("R1", 0, 1, 8'h00);
        check("R1", "sp", sp, 0);
        check("R1", "busy", busy, 0);
        check("R1", "mem_we", mem_we, 0);
        check("R1", "x_we", x_we, 0);

        // R2 R3 R4 R5 R11: table of presets and jumps
        for (int i = 0; i < 12; i++) begin
            logic [38:0] v;
            v = VEC[i];
            run_op(v[38:35], v[34:27], v[26], v[25], v[24:21], v[20:17]);
            check(i < 10 ? "R3/R4" : "R2/R5", $sformatf("vec%0d pc", i),
                  int'({pc_bank, pc_page, pc_step}), int'(v[16:4]));
            check("R11", $sformatf("vec%0d cycles", i), ncyc, int'(v[3:0]));
        end

        // R6 R13: call from page A step 94 with SP 00, wraps to FD
        run_op(4'd0, 8'h03, 0, 0, 0, 0);
        run_op(4'd7, 8'h50, 0, 0, 0, 0);
        check_pc("R6", 0, 3, 8'h50);
        check("R13", "sp after call", sp, 8'hFD);
        check("R6", "M(FF)", mem[8'hFF], 4'hA);
        check("R6", "M(FE)", mem[8'hFE], 4'h9);
        check("R6", "M(FD)", mem[8'hFD], 4'h5);
        check("R11", "call cycles", ncyc, 7);

        // R8: return
        run_op(4'd9, 8'h00, 0, 0, 0, 0);
        check_pc("R8", 0, 4'hA, 8'h95);
        check("R8", "sp after ret", sp, 8'h00);
        check("R11", "ret cycles", ncyc, 7);

        // R7: zero-page call from step FF, low nibble wraps in isolation
        run_op(4'd0, 8'h02, 0, 0, 0, 0);
        run_op(4'd1, 8'hFF, 0, 0, 0, 0);
        run_op(4'd8, 8'h40, 0, 0, 0, 0);
        check_pc("R7", 0, 0, 8'h40);
        check("R7", "sp after calz", sp, 8'hFD);
        check("R7", "M(FF)", mem[8'hFF], 4'h2);
        check("R7", "M(FE)", mem[8'hFE], 4'hF);
        check("R7", "M(FD)", mem[8'hFD], 4'h0);

        // R9: skip return with carry into page
        preload(8'hFD, 4'hF);
        preload(8'hFE, 4'hF);
        preload(8'hFF, 4'h2);
        run_op(4'd10, 8'h00, 0, 0, 0, 0);
        check_pc("R9", 0, 3, 8'h00);
        check("R13", "sp after rets", sp, 8'h00);
        check("R11", "rets cycles", ncyc, 12);

        // R10: data return
        preload(8'h00, 4'h7);
        preload(8'h01, 4'hC);
        preload(8'h02, 4'h4);
        idx_x = 8'h30;
        run_op(4'd11, 8'hB6, 0, 0, 0, 0);
        check_pc("R10", 0, 4, 8'hC7);
        check("R10", "sp after retd", sp, 8'h03);
        check("R10", "M(30)", mem[8'h30], 4'h6);
        check("R10", "M(31)", mem[8'h31], 4'hB);
        check("R10", "x strobe", xw_seen, 1);
        check("R10", "x value", xw_val, 8'h32);
        check("R11", "retd cycles", ncyc, 12);

        // R12: preset offered while busy is ignored
        @(negedge clk);
        op_valid = 1'b1; op = 4'd1; imm = 8'h12;
        @(negedge clk);
        op = 4'd0; imm = 8'h00;
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
        check_pc("R12", 0, 2, 8'h12);
        run_op(4'd1, 8'h34, 0, 0, 0, 0);
        check_pc("R12", 0, 2, 8'h34);

        // R12: undefined op code ignored
        @(negedge clk);
        op_valid = 1'b1; op = 4'hE; imm = 8'h99;
        @(negedge clk);
        check("R12", "busy on undefined", busy, 0);
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        check("R12", "busy later", busy, 0);
        check_pc("R12", 0, 2, 8'h34);
        check("R12", "sp unchanged", sp, 8'h03);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule